// File: doc/BRIEF.md
# Swap-Based Adaptive Address Codec

This block lowers switching activity on the low bits of an instruction address bus. It keeps a code table with one entry for each value of the W least significant address bits. For every valid address it drives that symbol's current code onto the bus. It then exchanges that code with the code held by the next symbol in counting order. A run of consecutive addresses therefore keeps sending one unchanged code. The upper address bits go out unencoded.

A matching decoder sits on the receiving side of the encoded bus and keeps its own copy of the table. It finds the symbol that owns the received code and rebuilds the address. It then applies the same exchange, driven by the symbol it decoded. Here the decoder is fed straight from the encoder's bus register, so the decoded address is available for checking in the cycle the encoded word appears. The encoder output is registered. The decoder adds only a parallel compare and a one-hot-to-index step, with no register after it.

Top module: `swap_addr_codec`

## Requirements
- R1: After reset the table maps every symbol k to code k, and both the bus output and the decoded address are zero.
- R2: A word accepted with `valid_i` high appears on `bus_o` one clock later, with bits [W-1:0] equal to the code the table held for the symbol `addr_i[W-1:0]` at the accepting edge.
- R3: After sending symbol s, the codes of s and of (s+1) mod 2^W are exchanged and all other entries keep their values, so consecutive symbols sent back to back carry the same code.
- R4: The successor of the all-ones symbol is symbol 0, so with W=2 sending 3 and then 0 from reset gives code 3 both times.
- R5: With W=2 and a table fresh from reset, the symbol stream 0 1 2 3 3 2 3 0 2 3 0 gives the codes 0 0 0 0 1 3 3 3 0 0 0.
- R6: Bits [AW-1:W] of `bus_o` equal the upper bits of the accepted address, unchanged.
- R7: While `valid_i` is low the table does not change and `bus_o` holds its last value, so the next valid word is encoded as if the idle cycles had not happened.
- R8: In the cycle an encoded word is on `bus_o`, `dec_addr_o` equals the address that produced it, with no extra register between bus and decoded output.
- R9: Exactly one decoder table entry matches the received code at all times, and the decoder stays in step with the encoder over long irregular streams.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address word present this cycle |
| addr_i | input | AW | Address to encode |
| bus_o | output | AW | Registered encoded bus: low W bits coded, upper bits passed through |
| dec_addr_o | output | AW | Address rebuilt by the decoder from `bus_o` |

## Verification
The bench builds the codec with AW=32 and W=2, so the table has only four entries. With so few entries the all-ones wrap to symbol 0 happens often, and the exact code stream of the worked example can be compared literally. The 32-bit width lets arbitrary upper bits be checked for clean pass-through. A long mixed stream of sequential runs, jumps and idle gaps then keeps a reference table in the bench in step with both encoder and decoder word by word.

// File: rtl/swap_codec_pkg.sv
`timescale 1ns/1ps
package swap_codec_pkg;
  localparam int unsigned MAX_W = 4;
  localparam int unsigned MAX_N = 1 << MAX_W;

  // index of the set bit in a one-hot vector (zero when empty)
  function automatic logic [MAX_W-1:0] onehot_idx(input logic [MAX_N-1:0] hot);
    logic [MAX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < MAX_N; i++) begin
      if (hot[i]) idx = idx | MAX_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/swap_table.sv
`timescale 1ns/1ps
module swap_table #(
  parameter int unsigned W = 2,
  localparam int unsigned N = 1 << W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  upd_i,
  input  logic [W-1:0]          sym_i,
  output logic [N-1:0][W-1:0]   tab_o
);
  logic [N-1:0][W-1:0] tab_q, tab_d;
  logic [W-1:0]        succ;

  assign succ = sym_i + 1'b1;  // wraps modulo 2^W

  always_comb begin
    tab_d        = tab_q;
    tab_d[sym_i] = tab_q[succ];
    tab_d[succ]  = tab_q[sym_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) tab_q[k] <= W'(k);
    end else if (upd_i) begin
      tab_q <= tab_d;
    end
  end

  assign tab_o = tab_q;

  p_swap_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> tab_q[$past(sym_i)] == $past(tab_q[succ]));

  p_swap_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> tab_q[$past(succ)] == $past(tab_q[sym_i]));

  p_idle_table_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(tab_q));
endmodule

// File: rtl/swap_encoder.sv
`timescale 1ns/1ps
module swap_encoder #(
  parameter int unsigned AW = 32,
  parameter int unsigned W  = 2,
  localparam int unsigned N = 1 << W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] bus_o,
  output logic          vld_o
);
  logic [N-1:0][W-1:0] tab;
  logic [W-1:0]        sym, code;
  logic [AW-1:0]       bus_q;
  logic                vld_q;
  logic [W-1:0]        last_sym_q;

  assign sym = addr_i[W-1:0];

  swap_table #(.W(W)) u_tab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (valid_i),
    .sym_i  (sym),
    .tab_o  (tab)
  );

  assign code = tab[sym];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q      <= '0;
      vld_q      <= 1'b0;
      last_sym_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        bus_q      <= {addr_i[AW-1:W], code};
        last_sym_q <= sym;
      end
    end
  end

  assign bus_o = bus_q;
  assign vld_o = vld_q;

  p_seq_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vld_q && sym == W'(last_sym_q + 1'b1))
      |=> bus_o[W-1:0] == $past(bus_o[W-1:0]));

  p_hi_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> bus_o[AW-1:W] == $past(addr_i[AW-1:W]));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(bus_o));
endmodule

// File: rtl/swap_decoder.sv
`timescale 1ns/1ps
module swap_decoder
  import swap_codec_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned W  = 2,
  localparam int unsigned N = 1 << W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [AW-1:0] bus_i,
  output logic [AW-1:0] addr_o
);
  logic [N-1:0][W-1:0] tab;
  logic [N-1:0]        hit;
  logic [W-1:0]        dec_sym;

  // parallel compare of every entry against the received code
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit[k] = (tab[k] == bus_i[W-1:0]);
  end

  assign dec_sym = W'(onehot_idx(MAX_N'(hit)));

  swap_table #(.W(W)) u_tab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (vld_i),
    .sym_i  (dec_sym),
    .tab_o  (tab)
  );

  assign addr_o = {bus_i[AW-1:W], dec_sym};

  p_one_owner_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit) == 1);
endmodule

// File: rtl/swap_addr_codec.sv
`timescale 1ns/1ps
module swap_addr_codec #(
  parameter int unsigned AW = 32,
  parameter int unsigned W  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] bus_o,
  output logic [AW-1:0] dec_addr_o
);
  if (W < 1 || W > swap_codec_pkg::MAX_W || W >= AW) begin : g_bad_w
    $error("swap_addr_codec: W out of range");
  end

  logic enc_vld;

  swap_encoder #(.AW(AW), .W(W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .addr_i  (addr_i),
    .bus_o   (bus_o),
    .vld_o   (enc_vld)
  );

  swap_decoder #(.AW(AW), .W(W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (enc_vld),
    .bus_i  (bus_o),
    .addr_o (dec_addr_o)
  );

  p_roundtrip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_vld |-> dec_addr_o == $past(addr_i));
endmodule

// File: tb/swap_addr_codec_tb.sv
`timescale 1ns/1ps
module swap_addr_codec_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned W  = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] bus_o, dec_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] mtab [4];
  logic [31:0]  lfsr = 32'hACE1_1234;

  always #10 clk_i = ~clk_i;

  swap_addr_codec #(.AW(AW), .W(W)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .addr_i     (addr_i),
    .bus_o      (bus_o),
    .dec_addr_o (dec_addr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 4; k++) mtab[k] = W'(k);
  endtask

  // drive one word, check it one edge later, then update the reference table
  task automatic send(input logic [31:0] a, output logic [W-1:0] code);
    logic [W-1:0] s, nx, tmp;
    s = a[W-1:0];
    code = mtab[s];
    valid_i = 1'b1;
    addr_i  = a;
    @(negedge clk_i);
    check("R2 code", 32'(bus_o[W-1:0]), 32'(code));
    check("R6 upper bits", bus_o[AW-1:W], a[AW-1:W]);
    check("R8 decode", dec_addr_o, a);
    nx = s + 1'b1;
    tmp = mtab[s]; mtab[s] = mtab[nx]; mtab[nx] = tmp;
  endtask

  task automatic idle(input int n);
    logic [AW-1:0] b;
    valid_i = 1'b0;
    b = bus_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      check("R7 bus hold", bus_o, b);
    end
  endtask

  task automatic t_reset();
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk_i);
    check("R1 bus in reset", bus_o, 32'h0);
    do_reset();
    check("R1 bus after reset", bus_o, 32'h0);
    check("R1 decode after reset", dec_addr_o, 32'h0);
  endtask

  task automatic t_example();
    logic [1:0] syms [11] = '{0, 1, 2, 3, 3, 2, 3, 0, 2, 3, 0};
    logic [1:0] exps [11] = '{0, 0, 0, 0, 1, 3, 3, 3, 0, 0, 0};
    logic [W-1:0] c;
    do_reset();
    for (int i = 0; i < 11; i++) begin
      send({28'h4000_010 + 28'(i), 2'b00, syms[i]}, c);
      check("R5 example stream", 32'(c), 32'(exps[i]));
    end
    idle(1);
  endtask

  task automatic t_wrap();
    logic [W-1:0] c;
    do_reset();
    send(32'h0000_0003, c);
    check("R1 identity first code", 32'(c), 32'd3);
    send(32'h0000_0004, c);
    check("R4 wrap to symbol 0", 32'(bus_o[W-1:0]), 32'd3);
    idle(1);
  endtask

  task automatic t_seq();
    logic [W-1:0] c0, c;
    do_reset();
    send(32'h1000_0005, c0);
    for (int i = 1; i < 12; i++) begin
      send(32'h1000_0005 + 32'(i), c);
      check("R3 sequential code constant", 32'(bus_o[W-1:0]), 32'(c0));
    end
    idle(2);
  endtask

  task automatic t_idle();
    logic [W-1:0] c0, c1;
    do_reset();
    send(32'h2000_0002, c0);
    idle(5);
    send(32'h2000_0003, c1);
    check("R7 table unchanged across idle", 32'(c1), 32'(c0));
    idle(1);
  endtask

  task automatic t_upper();
    logic [W-1:0] c;
    do_reset();
    send(32'hFFFF_FFFC, c);
    send(32'h0000_0001, c);
    send(32'h8000_0002, c);
    send(32'h5A5A_A5A7, c);
    idle(1);
  endtask

  task automatic t_long();
    logic [W-1:0] c;
    logic [31:0]  a;
    do_reset();
    a = 32'h0040_0000;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) a = lfsr;
      else a = a + 32'd1;
      if (lfsr[7:5] == 3'b111) idle(1);
      send(a, c);
      check("R9 decoder in step", dec_addr_o, a);
    end
    idle(1);
  endtask

  initial begin
    t_reset();
    t_example();
    t_wrap();
    t_seq();
    t_idle();
    t_upper();
    t_long();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule